// File: doc/BRIEF.md
# Triangle-Folding Phase Accumulator for a Memoryless Direct Digital Synthesizer

This block is the digital front end of a direct digital synthesizer that keeps no waveform table. Every clock a programmable phase step is added into a 9-bit phase register. That adder is cut into short slices, with a register on each carry between slices, so the clock rate is set by a 4-bit add and not a 9-bit one. The phase step is skewed into the slices, and the slice results are realigned afterwards, so the block behaves exactly like a flat 9-bit accumulator that sits behind a fixed pipeline delay.

The top phase bit folds the sawtooth. While the top bit is low, the lower eight phase bits go out as they are. While it is high, all eight are inverted. The result is a symmetric triangle code for a linear DAC, and the top bit goes out beside it as a sign. The analog shaping of the triangle into a sine or a pulse happens after the DAC and is not part of this block.

Top module: `tri_phase_core`

## Requirements
- R1: A synchronous reset, sampled high at a clock edge, leaves `triCode` = 0 and `phaseSign` = 0 after that edge, and clears every internal pipeline register.
- R2: Let S(j) be the sum modulo 512 of the `phaseInc` values sampled at the first j rising edges after reset, with S(j) = 0 for j ≤ 0. After the n-th edge, the outputs are the fold of S(n-4). The first four edges after reset therefore always give zero outputs.
- R3: Fold encoding: `triCode` equals bits 7..0 of the aligned phase when bit 8 is 0, and equals their bitwise inverse when bit 8 is 1.
- R4: The phase wraps modulo 512 and no overflow flag exists. An increment of 256 toggles the sign every cycle, and an increment of 511 steps the phase downward by one.
- R5: With an increment of 1, `triCode` climbs 0..255 and then falls 255..0, so the waveform repeats every 512 clocks.
- R6: An increment of 0 held at the input leaves both outputs constant from the fifth edge onwards.
- R7: A new increment value changes the output slope exactly four edges after it is sampled, even when the value changes on every cycle.
- R8: Carries cross the boundaries between the 4-bit slices and into the top bit correctly. Increments such as 15, 255 and 17 give the same phase as an unsegmented adder.
- R9: `phaseSign` equals bit 8 of the same phase that produced `triCode` in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phaseInc | input | 9 | Phase step added each clock |
| triCode | output | 8 | Folded triangle code for the DAC |
| phaseSign | output | 1 | Top phase bit, aligned with `triCode` |

## Verification
The delicate overlap is a change of increment in the same cycle that a slice carry is still travelling up the pipeline. If the skew on the increment and the skew on the carry disagree, the old slice value would be combined with the new carry. The bench provokes this by feeding a pseudo-random increment that changes on every clock, following runs of 15 and 255 that keep carries moving across both slice boundaries. It judges each output against a flat 9-bit model delayed by four edges, so any carry or slice that lands one cycle early or late shows up as a wrong code or a wrong sign.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic clr;     // synchronous clear of every pipeline register
    logic primed;  // pipeline has been filled since the last clear
  } tpcCtl_t;

  // Edges from sampling an increment to seeing it at the outputs:
  // one input register, one stage per slice, one fold register.
  function automatic int pipeLatency(input int numSeg);
    return numSeg + 2;
  endfunction

endpackage

// File: rtl/tpc_delay.sv
module tpc_delay
  import tpc_pkg::*;
#(
  parameter int W     = 4,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  tpcCtl_t      ctl,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] pipe [DEPTH];

  always_ff @(posedge clk) begin
    if (ctl.clr) begin
      for (int k = 0; k < DEPTH; k++) pipe[k] <= '0;
    end else begin
      pipe[0] <= din;
      for (int k = 1; k < DEPTH; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign dout = pipe[DEPTH-1];

endmodule

// File: rtl/tpc_segment.sv
module tpc_segment
  import tpc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  tpcCtl_t      ctl,
  input  logic [W-1:0] addend,
  input  logic         cin,
  output logic [W-1:0] acc,
  output logic         cout
);

  logic [W:0] total;

  always_comb total = {1'b0, acc} + {1'b0, addend} + {{W{1'b0}}, cin};

  always_ff @(posedge clk) begin
    if (ctl.clr) begin
      acc  <= '0;
      cout <= 1'b0;
    end else begin
      acc  <= total[W-1:0];
      cout <= total[W];
    end
  end

  // R8: a raised carry means the slice wrapped and cannot have grown
  carry_wrap_chk: assert property (@(posedge clk) disable iff (ctl.clr)
    ($past(!ctl.clr) && cout) |-> (acc <= $past(acc)));

  // R8: no carry means the slice cannot have shrunk
  carry_none_chk: assert property (@(posedge clk) disable iff (ctl.clr)
    ($past(!ctl.clr) && !cout) |-> (acc >= $past(acc)));

endmodule

// File: rtl/tpc_ctrl.sv
module tpc_ctrl
  import tpc_pkg::*;
#(
  parameter int NUM_SEG = 2
) (
  input  logic    clk,
  input  logic    rst,
  output tpcCtl_t ctl
);

  localparam int LAT   = pipeLatency(NUM_SEG);
  localparam int CNT_W = $clog2(LAT + 1);

  logic [CNT_W-1:0] fillCnt;

  always_ff @(posedge clk) begin
    if (rst)                          fillCnt <= '0;
    else if (fillCnt != CNT_W'(LAT))  fillCnt <= fillCnt + 1'b1;
  end

  always_comb begin
    ctl.clr    = rst;
    ctl.primed = (fillCnt == CNT_W'(LAT));
  end

endmodule

// File: rtl/tpc_datapath.sv
module tpc_datapath
  import tpc_pkg::*;
#(
  parameter int SEG_W   = 4,
  parameter int NUM_SEG = 2,
  localparam int PHASE_W = NUM_SEG * SEG_W + 1,
  localparam int LOW_W   = PHASE_W - 1
) (
  input  logic               clk,
  input  tpcCtl_t            ctl,
  input  logic [PHASE_W-1:0] incIn,
  output logic [LOW_W-1:0]   triOut,
  output logic               signOut
);

  localparam int NSTG = NUM_SEG + 1;
  localparam int LAT  = pipeLatency(NUM_SEG);
  localparam int ZR_W = $clog2(LAT + 2) + 1;

  logic [PHASE_W-1:0] incReg;
  logic [NSTG:0]      carryChain;
  logic [PHASE_W-1:0] alignedPhase;

  always_ff @(posedge clk) begin
    if (ctl.clr) incReg <= '0;
    else         incReg <= incIn;
  end

  assign carryChain[0] = 1'b0;

  for (genvar g = 0; g < NSTG; g++) begin : gStage
    localparam int LSB = g * SEG_W;
    localparam int W   = (g < NUM_SEG) ? SEG_W : 1;
    localparam int PRE = g;
    localparam int PST = NSTG - 1 - g;

    logic [W-1:0] slice;
    logic [W-1:0] accSeg;

    if (PRE > 0) begin : gSkew
      tpc_delay #(.W(W), .DEPTH(PRE)) skewIn (
        .clk(clk), .ctl(ctl), .din(incReg[LSB +: W]), .dout(slice));
    end else begin : gNoSkew
      assign slice = incReg[LSB +: W];
    end

    tpc_segment #(.W(W)) seg (
      .clk(clk), .ctl(ctl), .addend(slice), .cin(carryChain[g]),
      .acc(accSeg), .cout(carryChain[g+1]));

    if (PST > 0) begin : gDeskew
      tpc_delay #(.W(W), .DEPTH(PST)) deskew (
        .clk(clk), .ctl(ctl), .din(accSeg), .dout(alignedPhase[LSB +: W]));
    end else begin : gNoDeskew
      assign alignedPhase[LSB +: W] = accSeg;
    end
  end

  // Fold stage: top phase bit mirrors the lower bits
  logic             foldMsb;
  logic [LOW_W-1:0] foldLow;

  assign foldMsb = alignedPhase[PHASE_W-1];
  assign foldLow = alignedPhase[LOW_W-1:0];

  always_ff @(posedge clk) begin
    if (ctl.clr) begin
      triOut  <= '0;
      signOut <= 1'b0;
    end else begin
      triOut  <= foldLow ^ {LOW_W{foldMsb}};
      signOut <= foldMsb;
    end
  end

  // Run length of zero increments, used only by the hold check
  logic [ZR_W-1:0] zeroRun;

  always_ff @(posedge clk) begin
    if (ctl.clr || (incIn != '0))         zeroRun <= '0;
    else if (zeroRun != ZR_W'(LAT + 1))   zeroRun <= zeroRun + 1'b1;
  end

  // R1
  clr_zero_chk: assert property (@(posedge clk) disable iff (ctl.clr)
    $past(ctl.clr) |-> (triOut == '0 && !signOut));

  // R2
  fill_quiet_chk: assert property (@(posedge clk) disable iff (ctl.clr)
    !ctl.primed |-> (triOut == '0 && !signOut));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (ctl.clr)
    (zeroRun == ZR_W'(LAT + 1)) |-> ($stable(triOut) && $stable(signOut)));

endmodule

// File: rtl/tri_phase_core.sv
module tri_phase_core
  import tpc_pkg::*;
#(
  parameter int SEG_W   = 4,
  parameter int NUM_SEG = 2,
  localparam int PHASE_W = NUM_SEG * SEG_W + 1,
  localparam int LOW_W   = PHASE_W - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] phaseInc,
  output logic [LOW_W-1:0]   triCode,
  output logic               phaseSign
);

  tpcCtl_t ctl;

  tpc_ctrl #(.NUM_SEG(NUM_SEG)) ctrl (
    .clk(clk), .rst(rst), .ctl(ctl));

  tpc_datapath #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) dp (
    .clk(clk), .ctl(ctl), .incIn(phaseInc),
    .triOut(triCode), .signOut(phaseSign));

endmodule

// File: tb/tri_phase_core_test.sv
module tri_phase_core_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] phaseInc = '0;
  logic [7:0] triCode;
  logic       phaseSign;

  int vectors = 0;
  int misses  = 0;

  typedef struct {
    logic [7:0] triV;
    logic       sgn;
    string      tag;
  } item_t;

  item_t      sbq[$];
  logic [8:0] sumPipe[$];
  logic [8:0] accModel;
  logic [15:0] lf = 16'hACE1;

  always #2 clk = ~clk;

  tri_phase_core uut (
    .clk(clk), .rst(rst), .phaseInc(phaseInc),
    .triCode(triCode), .phaseSign(phaseSign));

  task automatic checkVal(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      misses++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Driver: applies one increment and queues the output due at that edge
  task automatic applyInc(input logic [8:0] d, input string tag);
    item_t      it;
    logic [8:0] s;
    @(negedge clk);
    rst      = 1'b0;
    phaseInc = d;
    accModel = accModel + d;
    sumPipe.push_back(accModel);
    s = sumPipe.pop_front();
    it.triV = s[8] ? ~s[7:0] : s[7:0];
    it.sgn  = s[8];
    it.tag  = tag;
    sbq.push_back(it);
  endtask

  // R1: reset with a nonzero increment present
  task automatic doReset();
    @(negedge clk);
    rst      = 1'b1;
    phaseInc = 9'h1AB;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      #1;
      checkVal("R1 triCode", triCode, 0);
      checkVal("R1 phaseSign", phaseSign, 0);
    end
    accModel = '0;
    sumPipe.delete();
    for (int k = 0; k < 4; k++) sumPipe.push_back('0);
  endtask

  // Monitor: compares queued expectations just after each edge
  always @(posedge clk) begin
    item_t it;
    #1;
    if (sbq.size() > 0) begin
      it = sbq.pop_front();
      checkVal(it.tag, triCode, it.triV);
      checkVal("R9 sign", phaseSign, it.sgn);
    end
  end

  initial begin
    #(4 * 50000);
    misses++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    doReset();

    // R2: fill latency, a single step shows after four edges
    applyInc(9'h055, "R2");
    for (int k = 0; k < 7; k++) applyInc(9'h000, "R2");

    // R5: unit step, full triangle period and a little more
    for (int k = 0; k < 520; k++) applyInc(9'h001, "R5");

    // R6: hold with zero increment
    for (int k = 0; k < 12; k++) applyInc(9'h000, "R6");

    // R8: carries across slice boundaries
    for (int k = 0; k < 40; k++) applyInc(9'h00F, "R8");
    for (int k = 0; k < 40; k++) applyInc(9'h0FF, "R8");
    for (int k = 0; k < 30; k++) applyInc(9'h011, "R8");

    // R4: wrap, sign toggling and downward stepping
    for (int k = 0; k < 12; k++) applyInc(9'h100, "R4");
    for (int k = 0; k < 24; k++) applyInc(9'h1FF, "R4");

    // R3: fold under an irregular step
    for (int k = 0; k < 30; k++) applyInc(9'h0C3, "R3");

    // R7: increment switching every cycle
    for (int k = 0; k < 200; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      applyInc(lf[8:0], "R7");
    end

    // R1 mid-stream, then R2 restart
    doReset();
    for (int k = 0; k < 12; k++) applyInc(9'h007, "R2");

    @(posedge clk);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule